// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Carry-Chained Shifts

This block is the purely combinational datapath core that a small 8-bit processor uses for every accumulator operation. It takes the accumulator value, a second operand, the incoming carry flag and a 5-bit operation code. In the same cycle it returns the new accumulator value and the four raw condition bits: sign, zero, carry and overflow. Deciding which flags get stored, holding the registers and sequencing instructions are left to the surrounding control logic.

Addition and subtraction always fold in the carry flag, so multi-byte sums and differences chain one byte at a time. The two rotate-through-carry shifts serve the same purpose for multi-byte shifts. Increment and decrement reuse the adder with a fixed internal operand, and the incoming carry is forced to zero for them. Compare exists only to produce the zero flag. It hands the accumulator back unchanged, so writing its result back is harmless.

Top module: `alu8_core`

## Requirements
- R1: Code 0 (add): the 9-bit value {flag_c_o, result_o} equals acc_i + opnd_i + carry_i. flag_s_o is result bit 7. flag_v_o is 1 when the two operands have the same sign and the result sign differs from it.
- R2: Code 1 (subtract): result_o equals acc_i - opnd_i - carry_i modulo 256. flag_c_o is 1 on a borrow (acc_i < opnd_i + carry_i). flag_v_o is 1 when the signed difference falls outside -128..127. flag_s_o is result bit 7.
- R3: Code 2 (increment) gives acc_i + 1 and code 3 (decrement) gives acc_i + 0xFF. carry_i has no effect on either. flag_c_o is the carry out of bit 7, flag_v_o is signed overflow, and flag_s_o is result bit 7.
- R4: Code 4 (negate) gives 0 - acc_i modulo 256. Code 11 (invert) gives ~acc_i. For both, flag_s_o, flag_c_o and flag_v_o are 0.
- R5: Codes 5 to 10 give, in that order, AND, OR, XOR, NAND, NOR and XNOR of acc_i and opnd_i. For these codes flag_s_o, flag_c_o and flag_v_o are 0.
- R6: Code 12 (compare): result_o equals acc_i unchanged. flag_z_o is 1 exactly when acc_i equals opnd_i. flag_s_o, flag_c_o and flag_v_o are 0.
- R7: Code 13 (logical right) shifts a 0 into bit 7 and bit 0 out to flag_c_o. Code 14 (logical left) shifts a 0 into bit 0 and bit 7 out to flag_c_o. For both, flag_s_o and flag_v_o are 0.
- R8: Code 15 (arithmetic right) keeps bit 7, copies it into bit 6 and sends bit 0 to flag_c_o. flag_s_o and flag_v_o are 0.
- R9: Code 16 (right through carry) puts carry_i into bit 7 and bit 0 into flag_c_o. Code 17 (left through carry) puts carry_i into bit 0 and bit 7 into flag_c_o. For both, flag_s_o and flag_v_o are 0.
- R10: For codes 0 to 11 and 13 to 17, flag_z_o is 1 exactly when result_o is zero.
- R11: Codes 18 to 31 are unassigned. They return acc_i unchanged and drive all four flags to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | 8 | Operation result |
| flag_s_o | output | 1 | Sign flag |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry / borrow flag |
| flag_v_o | output | 1 | Signed overflow flag |

## Verification
The assertions watch, whenever the inputs change, the relations that hold for whole classes of codes. These are the zero flag against the result, the cleared sign, carry and overflow bits of the logic and shift classes, the 9-bit sum of add, the bit rotation of the two carry shifts, compare leaving the accumulator unchanged and the pass-through of unassigned codes. Only the bench's scenarios show the exact arithmetic corner values. These are the borrow and overflow boundaries at 0x00, 0x7F and 0x80, carry_i having no effect on increment and decrement, the negation of 0x00 and 0x80, and the exact bit patterns of each shift with both carry values.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,
        OP_SUB  = 5'd1,
        OP_INC  = 5'd2,
        OP_DEC  = 5'd3,
        OP_NEG  = 5'd4,
        OP_AND  = 5'd5,
        OP_OR   = 5'd6,
        OP_XOR  = 5'd7,
        OP_NAND = 5'd8,
        OP_NOR  = 5'd9,
        OP_XNOR = 5'd10,
        OP_NOT  = 5'd11,
        OP_CMP  = 5'd12,
        OP_LSR  = 5'd13,
        OP_LSL  = 5'd14,
        OP_ASR  = 5'd15,
        OP_RRC  = 5'd16,
        OP_RLC  = 5'd17
    } alu_op_e;

    typedef struct packed {
        logic s;
        logic z;
        logic c;
        logic v;
    } alu_flags_t;

endpackage

// File: rtl/alu8_addsub.sv
// Shared adder: subtract is done as x + ~y + ~cin, and the borrow is the
// inverted carry out.
module alu8_addsub #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  logic             cin_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o,
    output logic             ovf_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] y_eff;
    logic             c_eff;
    logic [WIDTH:0]   total;

    always_comb begin
        y_eff = sub_i ? ~y_i : y_i;
        c_eff = sub_i ? ~cin_i : cin_i;
        total = {1'b0, x_i} + {1'b0, y_eff} + {{WIDTH{1'b0}}, c_eff};
    end

    assign sum_o   = total[MSB:0];
    assign carry_o = total[WIDTH] ^ sub_i;
    assign ovf_o   = (x_i[MSB] == y_eff[MSB]) && (total[MSB] != x_i[MSB]);

endmodule

// File: rtl/alu8_logic.sv
// Bitwise unit. Compare shares the XOR path.
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e          op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] res_o
);
    always_comb begin
        unique case (op_i)
            OP_AND:         res_o = a_i & b_i;
            OP_OR:          res_o = a_i | b_i;
            OP_XOR, OP_CMP: res_o = a_i ^ b_i;
            OP_NAND:        res_o = ~(a_i & b_i);
            OP_NOR:         res_o = ~(a_i | b_i);
            OP_XNOR:        res_o = ~(a_i ^ b_i);
            OP_NOT:         res_o = ~a_i;
            default:        res_o = '0;
        endcase
    end
endmodule

// File: rtl/alu8_shift.sv
// One-position shifter. The bit that leaves the word goes out as carry.
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e          op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] res_o,
    output logic             cout_o
);
    localparam int MSB = WIDTH - 1;

    logic fill_hi;
    logic fill_lo;
    logic go_right;

    always_comb begin
        go_right = (op_i == OP_LSR) || (op_i == OP_ASR) || (op_i == OP_RRC);
        unique case (op_i)
            OP_ASR:  fill_hi = a_i[MSB];
            OP_RRC:  fill_hi = cin_i;
            default: fill_hi = 1'b0;
        endcase
        fill_lo = (op_i == OP_RLC) ? cin_i : 1'b0;
        if (go_right) begin
            res_o  = {fill_hi, a_i[MSB:1]};
            cout_o = a_i[0];
        end else begin
            res_o  = {a_i[MSB-1:0], fill_lo};
            cout_o = a_i[MSB];
        end
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [OP_W-1:0]  op_i,
    input  logic [WIDTH-1:0] acc_i,
    input  logic [WIDTH-1:0] opnd_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] result_o,
    output logic             flag_s_o,
    output logic             flag_z_o,
    output logic             flag_c_o,
    output logic             flag_v_o
);
    localparam int MSB = WIDTH - 1;
    localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};
    localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};

    typedef struct packed {
        logic [WIDTH-1:0] result;
        alu_flags_t       flags;
    } alu_out_t;

    alu_op_e op;
    assign op = alu_op_e'(op_i);

    // adder operand selection
    logic [WIDTH-1:0] add_x, add_y, add_sum;
    logic             add_cin, add_sub, add_c, add_v;

    always_comb begin
        add_x   = (op == OP_NEG) ? '0 : acc_i;
        add_cin = (op == OP_ADD) || (op == OP_SUB) ? carry_i : 1'b0;
        add_sub = (op == OP_SUB) || (op == OP_NEG);
        unique case (op)
            OP_INC:  add_y = ONE;
            OP_DEC:  add_y = ONES;
            OP_NEG:  add_y = acc_i;
            default: add_y = opnd_i;
        endcase
    end

    alu8_addsub #(.WIDTH(WIDTH)) u_addsub (
        .x_i     (add_x),
        .y_i     (add_y),
        .cin_i   (add_cin),
        .sub_i   (add_sub),
        .sum_o   (add_sum),
        .carry_o (add_c),
        .ovf_o   (add_v)
    );

    logic [WIDTH-1:0] log_res;
    alu8_logic #(.WIDTH(WIDTH)) u_logic (
        .op_i  (op),
        .a_i   (acc_i),
        .b_i   (opnd_i),
        .res_o (log_res)
    );

    logic [WIDTH-1:0] sh_res;
    logic             sh_c;
    alu8_shift #(.WIDTH(WIDTH)) u_shift (
        .op_i   (op),
        .a_i    (acc_i),
        .cin_i  (carry_i),
        .res_o  (sh_res),
        .cout_o (sh_c)
    );

    alu_out_t out_d;

    always_comb begin
        out_d        = '0;
        out_d.result = acc_i;
        unique case (op)
            OP_ADD, OP_SUB, OP_INC, OP_DEC: begin
                out_d.result  = add_sum;
                out_d.flags.s = add_sum[MSB];
                out_d.flags.z = (add_sum == '0);
                out_d.flags.c = add_c;
                out_d.flags.v = add_v;
            end
            OP_NEG: begin
                out_d.result  = add_sum;
                out_d.flags.z = (add_sum == '0);
            end
            OP_AND, OP_OR, OP_XOR, OP_NAND, OP_NOR, OP_XNOR, OP_NOT: begin
                out_d.result  = log_res;
                out_d.flags.z = (log_res == '0);
            end
            OP_CMP: begin
                out_d.flags.z = (log_res == '0);
            end
            OP_LSR, OP_LSL, OP_ASR, OP_RRC, OP_RLC: begin
                out_d.result  = sh_res;
                out_d.flags.z = (sh_res == '0);
                out_d.flags.c = sh_c;
            end
            default: ;
        endcase
    end

    assign result_o = out_d.result;
    assign flag_s_o = out_d.flags.s;
    assign flag_z_o = out_d.flags.z;
    assign flag_c_o = out_d.flags.c;
    assign flag_v_o = out_d.flags.v;

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic [OP_W-1:0]  op_i,
    input logic [WIDTH-1:0] acc_i,
    input logic [WIDTH-1:0] opnd_i,
    input logic             carry_i,
    input logic [WIDTH-1:0] result_o,
    input logic             flag_s_o,
    input logic             flag_z_o,
    input logic             flag_c_o,
    input logic             flag_v_o
);
    localparam int MSB = WIDTH - 1;

    logic is_logic, is_shift, is_rsvd;
    logic [WIDTH:0] wide_sum;

    always_comb begin
        is_logic = (op_i >= OP_AND) && (op_i <= OP_CMP) || (op_i == OP_NEG);
        is_shift = (op_i >= OP_LSR) && (op_i <= OP_RLC);
        is_rsvd  = (op_i > OP_RLC);
        wide_sum = {1'b0, acc_i} + {1'b0, opnd_i} + {{WIDTH{1'b0}}, carry_i};

        if (op_i == OP_ADD)
            p_add_sum_r1: assert ({flag_c_o, result_o} == wide_sum)
                else $error("add sum mismatch");

        if (is_logic)
            p_logic_scv_zero_r5: assert (!flag_s_o && !flag_c_o && !flag_v_o)
                else $error("logic class drove S/C/V");

        if (op_i == OP_CMP)
            p_cmp_keeps_acc_r6: assert (result_o == acc_i && flag_z_o == (acc_i == opnd_i))
                else $error("compare altered acc or wrong Z");

        if (is_shift)
            p_shift_sv_zero_r7: assert (!flag_s_o && !flag_v_o)
                else $error("shift drove S/V");

        if (op_i == OP_RRC)
            p_rrc_rotate_r9: assert ({result_o, flag_c_o} == {carry_i, acc_i})
                else $error("right through carry wrong");

        if (op_i == OP_RLC)
            p_rlc_rotate_r9: assert ({flag_c_o, result_o} == {acc_i, carry_i})
                else $error("left through carry wrong");

        if (op_i != OP_CMP && !is_rsvd)
            p_zero_flag_r10: assert (flag_z_o == (result_o == '0))
                else $error("Z does not match result");

        if (is_rsvd)
            p_rsvd_pass_r11: assert (result_o == acc_i && !flag_s_o && !flag_z_o
                                     && !flag_c_o && !flag_v_o)
                else $error("unassigned code not a pass-through");

        if (op_i <= OP_DEC)
            p_arith_sign_r3: assert (flag_s_o == result_o[MSB])
                else $error("S not result MSB");
    end
endmodule

bind alu8_core alu8_core_chk #(.WIDTH(WIDTH)) u_chk (
    .op_i     (op_i),
    .acc_i    (acc_i),
    .opnd_i   (opnd_i),
    .carry_i  (carry_i),
    .result_o (result_o),
    .flag_s_o (flag_s_o),
    .flag_z_o (flag_z_o),
    .flag_c_o (flag_c_o),
    .flag_v_o (flag_v_o)
);

// File: tb/tb_alu8_core.sv
module tb_alu8_core;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic [4:0] op_i = '0;
    logic [7:0] acc_i = '0;
    logic [7:0] opnd_i = '0;
    logic       carry_i = 1'b0;
    logic [7:0] result_o;
    logic       flag_s_o, flag_z_o, flag_c_o, flag_v_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu8_core dut (
        .op_i     (op_i),
        .acc_i    (acc_i),
        .opnd_i   (opnd_i),
        .carry_i  (carry_i),
        .result_o (result_o),
        .flag_s_o (flag_s_o),
        .flag_z_o (flag_z_o),
        .flag_c_o (flag_c_o),
        .flag_v_o (flag_v_o)
    );

    typedef struct {
        int    op, a, b, ci;
        int    r, s, z, c, v;
        string tag;
    } exp_t;

    exp_t sb_q[$];

    function automatic int sgn(int x);
        return (x > 127) ? x - 256 : x;
    endfunction

    function automatic string tag_of(int op);
        if (op == 0) return "R1";
        if (op == 1) return "R2";
        if (op == 2 || op == 3) return "R3";
        if (op == 4 || op == 11) return "R4";
        if (op >= 5 && op <= 10) return "R5";
        if (op == 12) return "R6";
        if (op == 13 || op == 14) return "R7";
        if (op == 15) return "R8";
        if (op == 16 || op == 17) return "R9";
        return "R11";
    endfunction

    // reference model built from the requirement text
    function automatic exp_t model(int op, int a, int b, int ci);
        exp_t e;
        int t, sv;
        e.op = op; e.a = a; e.b = b; e.ci = ci;
        e.r = a; e.s = 0; e.c = 0; e.v = 0;
        case (op)
            0: begin t = a + b + ci; sv = sgn(a) + sgn(b) + ci;
                     e.r = t % 256; e.c = (t > 255); e.v = (sv > 127 || sv < -128); end
            1: begin t = a - b - ci; sv = sgn(a) - sgn(b) - ci;
                     e.r = (t + 512) % 256; e.c = (t < 0); e.v = (sv > 127 || sv < -128); end
            2: begin t = a + 1; sv = sgn(a) + 1;
                     e.r = t % 256; e.c = (t > 255); e.v = (sv > 127); end
            3: begin t = a + 255; sv = sgn(a) - 1;
                     e.r = t % 256; e.c = (t > 255); e.v = (sv < -128); end
            4: e.r = (256 - a) % 256;
            5: e.r = a & b;
            6: e.r = a | b;
            7: e.r = a ^ b;
            8: e.r = 255 - (a & b);
            9: e.r = 255 - (a | b);
            10: e.r = 255 - (a ^ b);
            11: e.r = 255 - a;
            12: e.r = a;
            13: begin e.r = a / 2; e.c = a % 2; end
            14: begin e.r = (a * 2) % 256; e.c = a / 128; end
            15: begin e.r = a / 2 + (a / 128) * 128; e.c = a % 2; end
            16: begin e.r = a / 2 + ci * 128; e.c = a % 2; end
            17: begin e.r = (a * 2) % 256 + ci; e.c = a / 128; end
            default: ;
        endcase
        if (op <= 3) e.s = e.r / 128;
        if (op == 12)      e.z = (a == b);
        else if (op > 17)  e.z = 0;
        else               e.z = (e.r == 0);
        e.tag = tag_of(op);
        return e;
    endfunction

    task automatic drive(input int op, input int a, input int b, input int ci);
        @(negedge clk);
        op_i    = op[4:0];
        acc_i   = a[7:0];
        opnd_i  = b[7:0];
        carry_i = ci[0];
        sb_q.push_back(model(op, a, b, ci));
    endtask

    // monitor: inputs were set at the previous falling edge, outputs settled
    always @(posedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            string ztag;
            e = sb_q.pop_front();
            checks++;
            if (int'(result_o) != e.r || int'(flag_s_o) != e.s ||
                int'(flag_c_o) != e.c || int'(flag_v_o) != e.v) begin
                errors++;
                $display("FAIL %s op=%0d a=%02h b=%02h ci=%0d: got r=%02h s%0d c%0d v%0d exp r=%02h s%0d c%0d v%0d",
                         e.tag, e.op, e.a, e.b, e.ci, result_o, flag_s_o, flag_c_o, flag_v_o,
                         e.r, e.s, e.c, e.v);
            end
            ztag = (e.op == 12 || e.op > 17) ? e.tag : "R10";
            checks++;
            if (int'(flag_z_o) != e.z) begin
                errors++;
                $display("FAIL %s op=%0d a=%02h b=%02h ci=%0d: got z=%0d exp z=%0d",
                         ztag, e.op, e.a, e.b, e.ci, flag_z_o, e.z);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int lfsr;
        // idle state: all-zero inputs, add of zeros gives zero
        drive(0, 8'h00, 8'h00, 0);
        // R1 add with carry-in, overflow and carry out
        drive(0, 8'h7F, 8'h01, 0);
        drive(0, 8'hFF, 8'h01, 0);
        drive(0, 8'h10, 8'h20, 1);
        drive(0, 8'h80, 8'h80, 1);
        // R2 subtract with borrow
        drive(1, 8'h00, 8'h01, 0);
        drive(1, 8'h80, 8'h01, 0);
        drive(1, 8'h05, 8'h05, 0);
        drive(1, 8'h05, 8'h04, 1);
        drive(1, 8'h7F, 8'hFF, 1);
        // R3 carry_i must not affect increment/decrement
        drive(2, 8'hFF, 8'h00, 1);
        drive(2, 8'h7F, 8'h33, 1);
        drive(3, 8'h00, 8'h00, 1);
        drive(3, 8'h80, 8'h00, 1);
        drive(3, 8'h01, 8'h00, 0);
        // R4 negate and invert
        drive(4, 8'h00, 8'h00, 1);
        drive(4, 8'h01, 8'h00, 0);
        drive(4, 8'h80, 8'h00, 1);
        drive(11, 8'hFF, 8'h00, 1);
        drive(11, 8'h3C, 8'h00, 0);
        // R5 bitwise set
        for (int op = 5; op <= 10; op++) begin
            drive(op, 8'hCA, 8'h5C, 1);
            drive(op, 8'hFF, 8'hFF, 0);
            drive(op, 8'h00, 8'h00, 1);
        end
        // R6 compare
        drive(12, 8'hA5, 8'hA5, 1);
        drive(12, 8'hA5, 8'hA4, 0);
        drive(12, 8'h00, 8'h01, 1);
        // R7 R8 R9 shifts with both carry values
        for (int op = 13; op <= 17; op++) begin
            drive(op, 8'h81, 8'h00, 0);
            drive(op, 8'h81, 8'h00, 1);
            drive(op, 8'h01, 8'h00, 0);
            drive(op, 8'h80, 8'h00, 0);
            drive(op, 8'h40, 8'h00, 1);
        end
        // R11 unassigned codes
        drive(18, 8'h00, 8'h12, 1);
        drive(31, 8'hC3, 8'hFF, 1);
        // sweep every code with pseudo-random operands
        lfsr = 32'h1ACE;
        for (int i = 0; i < 640; i++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
            drive(i % 32, lfsr & 255, (lfsr >> 8) & 255, (lfsr >> 3) & 1);
        end
        wait (sb_q.size() == 0);
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule